// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register side of a general-purpose I/O controller. Its pins are grouped into banks of a fixed width, and each bank has a data register and a direction register on a simple 32-bit register bus. A processor writes direction bits to decide which pins are driven. It writes data bits to set what those pins drive, and it reads the data register to see either the level on the pads or the value being driven.

The bank registers are not packed end to end. Every bank uses an eight-byte slot, and bank 0 starts at byte 0x08. An address window from 0x90 to 0x9F belongs to a separate interrupt unit, so any bank slot that would land at or above 0x90 is moved up by 0x10. The decoder skips that window and answers it as empty. Pad inputs pass through a two-flop synchroniser before they can reach the read data. Reads return their data one cycle after the request.

Top module: `gpio_bank_regfile`

## Requirements
- R1: Pin p belongs to bank p / LINES_PER_BANK, bit p % LINES_PER_BANK. The data register of bank n is at byte address (n+1)*8 whenever that value is below 0x90.
- R2: A bank address computed at or above 0x90 is moved up by 0x10. With 8 lines per bank, bank 17 is at 0xA0 and bank 18 is at 0xA8. Reads from 0x90 to 0x9F return zero, and writes there change no pad output or enable.
- R3: The direction register of a bank is at its base + 4. Only word-aligned addresses are decoded: base + 1, base + 2 and base + 3 are unmapped.
- R4: A direction bit of 1 makes the pin an input, with pad_oe low. A direction bit of 0 makes it an output, with pad_oe high and pad_out equal to the stored data bit.
- R5: A data write is stored even while the pin is an input. pad_out shows the stored value at once, and clearing the direction bit later drives that preloaded value with no further data write.
- R6: A data-register read returns, for an input pin, the pad level after two synchroniser flops, so the pad must be steady for two clock edges before the read request. For an output pin it returns the stored data bit.
- R7: The read data is registered. It holds the result in the cycle after a read request and is zero in the cycle after any cycle with no read request.
- R8: After synchronous reset every direction bit is 1 and every data bit is 0, so pad_oe and pad_out are all zero.
- R9: Addresses outside every bank slot read as zero and ignore writes. This covers 0x00 to 0x07 and everything above the last bank's direction register.
- R10: Register bits at or above LINES_PER_BANK read as zero. In the last bank, bits for pins at or above PIN_COUNT read as zero and ignore writes. With the defaults, that bank holds only 4 pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| pad_in | input | PIN_COUNT | Asynchronous pad levels |
| pad_out | output | PIN_COUNT | Value driven toward the pads |
| pad_oe | output | PIN_COUNT | Output enable per pin (1 = drive) |

## Verification
A corrupted direction bit shows on pad_oe in the very next cycle. A corrupted data bit shows on pad_out in the same way, whether the pin is an input or an output. That is why the bench compares both full vectors against its model after every test. A decode fault that sends one bank's access to the wrong slot shows up as a wrong value on read-back of another bank's address, or as a changed enable on a pin that should not have moved, one cycle after the access. A fault in the synchroniser or the input/output select appears only on a data read: it returns a stale or wrong level in the cycle after the read request.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Byte address window owned by the interrupt unit.
    localparam int unsigned HOLE_LO   = 32'h90;
    localparam int unsigned HOLE_SPAN = 32'h10;
    localparam int unsigned SLOT_BYTES = 8;
    localparam int unsigned DIR_OFS    = 4;

    // Decoded access target.
    typedef struct packed {
        logic       hit;
        logic       is_dir;
        logic [7:0] bank;
    } gpio_sel_t;

    // Base byte address of a bank slot, stepping over the reserved window.
    function automatic int unsigned bank_base(int unsigned n);
        int unsigned a;
        a = (n + 1) * SLOT_BYTES;
        if (a >= HOLE_LO) a = a + HOLE_SPAN;
        return a;
    endfunction

    function automatic int unsigned min_u(int unsigned a, int unsigned b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBANK  = 19
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_sel_t         sel
);
    always_comb begin
        sel = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (32'(addr) == bank_base(b)) begin
                sel.hit    = 1'b1;
                sel.is_dir = 1'b0;
                sel.bank   = 8'(b);
            end else if (32'(addr) == bank_base(b) + DIR_OFS) begin
                sel.hit    = 1'b1;
                sel.is_dir = 1'b1;
                sel.bank   = 8'(b);
            end
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [31:0]  wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] drive,
    output logic [W-1:0] oe,
    output logic [31:0]  rd_data,
    output logic [31:0]  rd_dir
);
    logic [W-1:0] data_q;
    logic [W-1:0] dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '1;
        end else begin
            if (wr_data) data_q <= wdata[W-1:0];
            if (wr_dir)  dir_q  <= wdata[W-1:0];
        end
    end

    assign drive   = data_q;
    assign oe      = ~dir_q;
    assign rd_data = 32'((dir_q & pin_sync) | (~dir_q & data_q));
    assign rd_dir  = 32'(dir_q);

    // R5: a data write to an all-input bank is kept and leaves drivers off.
    assert_preload_kept_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !wr_dir && (&dir_q)) |=> (drive == $past(wdata[W-1:0]) && oe == '0));

    // R4: without a direction write the enables do not move.
    assert_oe_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(oe));
endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
    import gpio_bank_pkg::*;
#(
    parameter int LINES_PER_BANK = 8,
    parameter int PIN_COUNT      = 148,
    parameter int ADDR_W         = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rsp_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe
);
    localparam int NBANK = (PIN_COUNT + LINES_PER_BANK - 1) / LINES_PER_BANK;

    gpio_sel_t             sel;
    logic [PIN_COUNT-1:0]  pad_sync;
    logic [31:0]           bank_rd_data [NBANK];
    logic [31:0]           bank_rd_dir  [NBANK];
    logic [31:0]           rd_next;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    gpio_in_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO = b * LINES_PER_BANK;
        localparam int W  = int'(min_u(LINES_PER_BANK, PIN_COUNT - LO));
        logic sel_me;
        logic wr_d;
        logic wr_r;

        assign sel_me = req_valid && req_write && sel.hit && (sel.bank == 8'(b));
        assign wr_d   = sel_me && !sel.is_dir;
        assign wr_r   = sel_me &&  sel.is_dir;

        gpio_bank #(.W(W)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_data  (wr_d),
            .wr_dir   (wr_r),
            .wdata    (req_wdata),
            .pin_sync (pad_sync[LO +: W]),
            .drive    (pad_out[LO +: W]),
            .oe       (pad_oe[LO +: W]),
            .rd_data  (bank_rd_data[b]),
            .rd_dir   (bank_rd_dir[b])
        );
    end

    always_comb begin
        rd_next = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (sel.hit && sel.bank == 8'(b))
                rd_next = sel.is_dir ? bank_rd_dir[b] : bank_rd_data[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          rsp_rdata <= '0;
        else if (req_valid && !req_write) rsp_rdata <= rd_next;
        else                              rsp_rdata <= '0;
    end

    // R2: the reserved window always answers with zero.
    assert_hole_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && 32'(req_addr) >= HOLE_LO
         && 32'(req_addr) < HOLE_LO + HOLE_SPAN) |=> (rsp_rdata == '0));

    // R9: a write that hits no register leaves every pad output alone.
    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !sel.hit) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R7: no read request, no read data.
    assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> (rsp_rdata == '0));

    // R8: leaving reset, every pin is an undriven input holding zero.
    assert_reset_state_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0));
endmodule

// File: tb/sim_gpio_bank_regfile.sv
`timescale 1ns/1ps
module sim_gpio_bank_regfile;
    localparam int LPB = 8;
    localparam int PIN = 148;
    localparam int NB  = 19;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic [7:0]     req_addr  = '0;
    logic [31:0]    req_wdata = '0;
    logic [31:0]    rsp_rdata;
    logic [PIN-1:0] pad_in = '0;
    logic [PIN-1:0] pad_out;
    logic [PIN-1:0] pad_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [PIN-1:0] m_data;
    logic [PIN-1:0] m_dir;

    always #2 clk = ~clk;

    gpio_bank_regfile #(.LINES_PER_BANK(LPB), .PIN_COUNT(PIN), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic int slot(int n);
        int a;
        a = (n + 1) * 8;
        if (a >= 144) a = a + 16;
        return a;
    endfunction

    function automatic logic [31:0] model_read(logic [7:0] a);
        logic [31:0] r;
        r = '0;
        for (int b = 0; b < NB; b++) begin
            for (int j = 0; j < LPB; j++) begin
                int p;
                p = b * LPB + j;
                if (p < PIN) begin
                    if (int'(a) == slot(b))
                        r[j] = m_dir[p] ? pad_in[p] : m_data[p];
                    else if (int'(a) == slot(b) + 4)
                        r[j] = m_dir[p];
                end
            end
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [PIN-1:0] act,
                         input logic [PIN-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        for (int b = 0; b < NB; b++) begin
            for (int j = 0; j < LPB; j++) begin
                int p;
                p = b * LPB + j;
                if (p < PIN) begin
                    if (int'(a) == slot(b))     m_data[p] = d[j];
                    if (int'(a) == slot(b) + 4) m_dir[p]  = d[j];
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read_check(input logic [7:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp = model_read(a);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_rdata == exp, req, PIN'(rsp_rdata), PIN'(exp));
    endtask

    task automatic check_pads(input string req);
        check(pad_oe == ~m_dir, req, pad_oe, ~m_dir);
        check(pad_out == m_data, req, pad_out, m_data);
    endtask

    task automatic t_reset;
        check(pad_oe == '0, "R8 oe", pad_oe, '0);
        check(pad_out == '0, "R8 out", pad_out, '0);
        check(rsp_rdata == '0, "R8 rdata", PIN'(rsp_rdata), '0);
        bus_read_check(8'h0C, "R8 dir bank0");
        bus_read_check(8'hAC, "R10 dir last bank 4 pins");
    endtask

    task automatic t_map;
        bus_write(8'h0C, 32'h0000_00F0);   // bank 0 dir
        bus_write(8'h14, 32'h0000_0033);   // bank 1 dir
        bus_write(8'h8C, 32'h0000_0055);   // bank 16 dir at 0x88+4
        bus_write(8'hA4, 32'h0000_0066);   // bank 17 dir moved to 0xA0+4
        bus_write(8'hAC, 32'h0000_000A);   // bank 18 dir at 0xA8+4
        bus_write(8'h08, 32'h0000_00C3);
        bus_write(8'hA0, 32'h0000_0099);
        bus_read_check(8'h0C, "R1 bank0 dir");
        bus_read_check(8'h14, "R1 bank1 dir");
        bus_read_check(8'h8C, "R1 bank16 dir");
        bus_read_check(8'hA4, "R2 bank17 dir");
        bus_read_check(8'hAC, "R2 bank18 dir");
        bus_read_check(8'hA0, "R3 bank17 data");
        check_pads("R4 pads after map");
    endtask

    task automatic t_hole;
        bus_write(8'h90, 32'hFFFF_FFFF);
        bus_write(8'h94, 32'h0000_0000);
        bus_write(8'h98, 32'h0000_0000);
        bus_write(8'h9C, 32'hFFFF_FFFF);
        bus_read_check(8'h90, "R2 hole 90");
        bus_read_check(8'h94, "R2 hole 94");
        bus_read_check(8'h9C, "R2 hole 9C");
        bus_write(8'h0D, 32'h0000_0000);  // unaligned, bank 0 dir+1
        bus_read_check(8'h0D, "R3 unaligned");
        check_pads("R2 pads unchanged by hole");
    endtask

    task automatic t_unmapped;
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h04, 32'h0000_0000);
        bus_write(8'hB0, 32'h0000_0000);
        bus_write(8'hFC, 32'hFFFF_FFFF);
        bus_read_check(8'h00, "R9 addr 00");
        bus_read_check(8'h04, "R9 addr 04");
        bus_read_check(8'hB0, "R9 addr B0");
        check_pads("R9 pads unchanged");
    endtask

    task automatic t_preload;
        bus_write(8'h18, 32'h0000_00A5);   // bank 2 data while all input
        check(pad_oe[23:16] == 8'h00, "R5 still input", PIN'(pad_oe[23:16]), '0);
        check(pad_out[23:16] == 8'hA5, "R5 stored", PIN'(pad_out[23:16]), PIN'(8'hA5));
        bus_write(8'h1C, 32'h0000_0000);   // bank 2 to output
        check(pad_oe[23:16] == 8'hFF, "R4 enable", PIN'(pad_oe[23:16]), PIN'(8'hFF));
        check(pad_out[23:16] == 8'hA5, "R5 drives preload", PIN'(pad_out[23:16]), PIN'(8'hA5));
        bus_read_check(8'h18, "R6 output bits read stored");
    endtask

    task automatic t_input;
        bus_write(8'h24, 32'h0000_000F);   // bank 3: low nibble in
        bus_write(8'h20, 32'h0000_003C);
        @(negedge clk);
        pad_in[31:24] = 8'h96;
        pad_in[7:0]   = 8'h5A;
        repeat (3) @(negedge clk);
        bus_read_check(8'h20, "R6 mixed bank3");
        bus_read_check(8'h08, "R6 bank0 mixed");
        pad_in[31:24] = 8'h69;
        repeat (3) @(negedge clk);
        bus_read_check(8'h20, "R6 new pad level");
    endtask

    task automatic t_upper;
        bus_write(8'h30, 32'hFFFF_FFFF);
        bus_read_check(8'h30, "R10 bits above bank width");
        bus_write(8'hAC, 32'hFFFF_FF00);
        bus_read_check(8'hAC, "R10 last bank dir");
        bus_write(8'hA8, 32'h0000_00FF);
        bus_read_check(8'hA8, "R10 last bank data");
        check_pads("R10 pads");
    endtask

    task automatic t_timing;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h14;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_rdata == 32'h33, "R7 read valid next cycle", PIN'(rsp_rdata), PIN'(32'h33));
        @(negedge clk);
        check(rsp_rdata == '0, "R7 zero after idle", PIN'(rsp_rdata), '0);
    endtask

    initial begin
        m_data = '0;
        m_dir  = '1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_hole();
        t_unmapped();
        t_preload();
        t_input();
        t_upper();
        t_timing();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule